// File: doc/BRIEF.md
# Load/Store Request Handshake Master

This block sits on the requesting side of a memory port that allows one access in flight. A local client hands it a command through a valid/ready pair. The command says whether the access is a load or a store, and carries the address and, for a store, the write data. The master raises the matching request line and holds the address, together with its valid flag, steady on the port. It then waits for the memory side to answer with a one-cycle address-accepted pulse or a one-cycle address-exception pulse.

After the address is accepted, a load waits any number of cycles for a one-cycle data-valid pulse and captures the data on that cycle. A store drives its data strobe for exactly one cycle, right after the acceptance. The master then drops every request line and sends the client a one-cycle result that carries the load data and an error flag. The error flag is set when the address was refused. A kill input aborts the transaction and returns the master to idle. The kill is also passed through to the memory side, so that the port resets as well.

The memory side indicates an open access with a busy signal. The master takes a new command only in idle, only while busy is low and only while no kill is present. After a store, the port releases busy one cycle after the strobe or later, and the master does not accept the next command until busy is low.

Top module: `ldst_req_master`

## Requirements
- R1: `cmd_ready` is high only when the master is idle, `port_busy` is low and `kill_req` is low. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: From the cycle after a command is taken, exactly one request line is high: `port_st_req` when `cmd_is_store` was 1, `port_ld_req` when it was 0. `port_addr_vld` is high in the same cycles, and `port_addr` equals the command address and stays unchanged until the lines drop. While idle, all of these are 0.
- R3: While waiting for the address answer, `port_addr_exc` ends the transaction and takes priority over a simultaneous `port_addr_ack`. In the next cycle all request lines are low, no store strobe is issued, and `rsp_valid`=1 with `rsp_error`=1 and `rsp_rdata`=0.
- R4: After an accepted load address, the master waits any number of cycles for `port_ld_vld`. In the cycle after that pulse, `rsp_valid`=1, `rsp_error`=0, `rsp_rdata` equals the `port_ld_data` present during the pulse, and the request lines are low.
- R5: For a store, `port_st_vld` is high for exactly the one cycle after the cycle in which `port_addr_ack` arrived, and never at any other time. During that cycle `port_st_data` equals the command data.
- R6: In the cycle after the store strobe, the request lines are low, and `rsp_valid`=1 with `rsp_error`=0 and `rsp_rdata`=0.
- R7: After a transaction completes, no new command is taken while `port_busy` is still high.
- R8: `port_kill` equals `kill_req` in the same cycle. In the cycle after `kill_req`, the request lines and `port_st_vld` are low, no result is produced, and the master is idle.
- R9: `port_addr_ack`, `port_addr_exc` and `port_ld_vld` pulses that arrive while the master is not waiting for them have no effect: no result is produced and idle remains idle.
- R10: `rsp_valid` is a single-cycle pulse. `rsp_rdata` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Local command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_is_store | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Store data |
| kill_req | input | 1 | Abort the current transaction |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_error | output | 1 | Address refused |
| rsp_rdata | output | DATA_W | Load data (0 otherwise) |
| port_busy | input | 1 | Memory side has an open access |
| port_ld_req | output | 1 | Load request |
| port_st_req | output | 1 | Store request |
| port_addr_vld | output | 1 | Address valid |
| port_addr | output | ADDR_W | Request address |
| port_addr_ack | input | 1 | Address accepted pulse |
| port_addr_exc | input | 1 | Address exception pulse |
| port_ld_vld | input | 1 | Load data valid pulse |
| port_ld_data | input | DATA_W | Load data |
| port_st_vld | output | 1 | Store data strobe |
| port_st_data | output | DATA_W | Store data |
| port_kill | output | 1 | Abort forwarded to the port |

## Verification
The hardest situations to reach are the ones a well-behaved memory side never produces. Examples are an exception and an acceptance in the same cycle, answer pulses while the master is idle, and busy held high past the point where the master has already finished. The bench memory responder has mode knobs that raise both address answers together, hold busy for extra cycles after completion, and inject stray pulses. A kill is also timed to land while a long-latency load is still waiting for its data.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_LOAD  = 2'd2,
    PH_STORE = 2'd3
  } ldst_phase_e;

  typedef struct packed {
    logic exc;
    logic ld_done;
    logic st_done;
  } ldst_evt_t;

  function automatic logic phase_active(input ldst_phase_e p);
    return p != PH_IDLE;
  endfunction

  function automatic ldst_phase_e phase_next(
    input ldst_phase_e cur,
    input logic        kill,
    input logic        accept,
    input logic        is_store,
    input logic        ack,
    input logic        exc,
    input logic        ld_vld
  );
    ldst_phase_e nxt;
    nxt = cur;
    if (kill) begin
      nxt = PH_IDLE;
    end else begin
      case (cur)
        PH_IDLE:  if (accept) nxt = PH_ADDR;
        PH_ADDR: begin
          if (exc)      nxt = PH_IDLE;
          else if (ack) nxt = is_store ? PH_STORE : PH_LOAD;
        end
        PH_LOAD:  if (ld_vld) nxt = PH_IDLE;
        PH_STORE: nxt = PH_IDLE;
        default:  nxt = PH_IDLE;
      endcase
    end
    return nxt;
  endfunction

  function automatic ldst_evt_t phase_events(
    input ldst_phase_e cur,
    input logic        kill,
    input logic        exc,
    input logic        ld_vld
  );
    ldst_evt_t e;
    e.exc     = !kill && (cur == PH_ADDR) && exc;
    e.ld_done = !kill && (cur == PH_LOAD) && ld_vld;
    e.st_done = !kill && (cur == PH_STORE);
    return e;
  endfunction

endpackage

// File: rtl/ldst_cmd_hold.sv
module ldst_cmd_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              cmd_is_store,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              op_store,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_store   <= 1'b0;
      hold_addr  <= '0;
      hold_wdata <= '0;
    end else if (accept) begin
      op_store   <= cmd_is_store;
      hold_addr  <= cmd_addr;
      hold_wdata <= cmd_is_store ? cmd_wdata : '0;
    end
  end

endmodule

// File: rtl/ldst_phase_ctl.sv
module ldst_phase_ctl
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        kill,
  input  logic        cmd_valid,
  input  logic        port_busy,
  input  logic        op_store,
  input  logic        ack,
  input  logic        exc,
  input  logic        ld_vld,
  output ldst_phase_e phase,
  output logic        cmd_ready,
  output logic        accept,
  output ldst_evt_t   evt
);

  ldst_phase_e phase_q;
  ldst_phase_e phase_d;

  assign cmd_ready = (phase_q == PH_IDLE) && !port_busy && !kill;
  assign accept    = cmd_ready && cmd_valid;
  assign phase_d   = phase_next(phase_q, kill, accept, op_store, ack, exc, ld_vld);
  assign evt       = phase_events(phase_q, kill, exc, ld_vld);
  assign phase     = phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

endmodule

// File: rtl/ldst_rsp_out.sv
module ldst_rsp_out
  import ldst_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  ldst_evt_t         evt,
  input  logic [DATA_W-1:0] ld_data,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= evt.exc | evt.ld_done | evt.st_done;
      rsp_error <= evt.exc;
      rsp_rdata <= evt.ld_done ? ld_data : '0;
    end
  end

endmodule

// File: rtl/ldst_req_master.sv
module ldst_req_master
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_store,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              kill_req,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              port_busy,
  output logic              port_ld_req,
  output logic              port_st_req,
  output logic              port_addr_vld,
  output logic [ADDR_W-1:0] port_addr,
  input  logic              port_addr_ack,
  input  logic              port_addr_exc,
  input  logic              port_ld_vld,
  input  logic [DATA_W-1:0] port_ld_data,
  output logic              port_st_vld,
  output logic [DATA_W-1:0] port_st_data,
  output logic              port_kill
);

  ldst_phase_e       phase;
  ldst_evt_t         evt;
  logic              accept;
  logic              op_store;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_wdata;

  // named internal events for the checker
  logic idle_w;
  logic wait_addr_w;
  logic wait_load_w;
  logic active_w;

  ldst_phase_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .kill      (kill_req),
    .cmd_valid (cmd_valid),
    .port_busy (port_busy),
    .op_store  (op_store),
    .ack       (port_addr_ack),
    .exc       (port_addr_exc),
    .ld_vld    (port_ld_vld),
    .phase     (phase),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .evt       (evt)
  );

  ldst_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .cmd_is_store (cmd_is_store),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .op_store     (op_store),
    .hold_addr    (hold_addr),
    .hold_wdata   (hold_wdata)
  );

  ldst_rsp_out #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .ld_data   (port_ld_data),
    .rsp_valid (rsp_valid),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata)
  );

  assign active_w    = phase_active(phase);
  assign idle_w      = !active_w;
  assign wait_addr_w = (phase == PH_ADDR);
  assign wait_load_w = (phase == PH_LOAD);

  assign port_ld_req   = active_w && !op_store;
  assign port_st_req   = active_w && op_store;
  assign port_addr_vld = active_w;
  assign port_addr     = active_w ? hold_addr : '0;
  assign port_st_vld   = (phase == PH_STORE);
  assign port_st_data  = (phase == PH_STORE) ? hold_wdata : '0;
  assign port_kill     = kill_req;

endmodule

// File: rtl/ldst_req_master_chk.sv
module ldst_req_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              kill_req,
  input logic              rsp_valid,
  input logic              rsp_error,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              port_busy,
  input logic              port_ld_req,
  input logic              port_st_req,
  input logic              port_addr_vld,
  input logic [ADDR_W-1:0] port_addr,
  input logic              port_addr_ack,
  input logic              port_addr_exc,
  input logic              port_ld_vld,
  input logic [DATA_W-1:0] port_ld_data,
  input logic              port_st_vld,
  input logic              idle_w,
  input logic              wait_addr_w,
  input logic              wait_load_w
);

  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!port_busy && !kill_req));

  // R2
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    !(port_ld_req && port_st_req));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (port_addr_vld && $past(port_addr_vld)) |-> $stable(port_addr));

  // R3
  exc_end_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_addr_w && port_addr_exc && !kill_req) |=>
      (rsp_valid && rsp_error && !port_ld_req && !port_st_req && !port_st_vld));

  // R4
  ld_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_load_w && port_ld_vld && !kill_req) |=>
      (rsp_valid && !rsp_error && rsp_rdata == $past(port_ld_data)));

  // R5
  st_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    port_st_vld |-> $past(port_addr_ack && wait_addr_w && !port_addr_exc));

  // R5
  st_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    port_st_vld |=> !port_st_vld);

  // R8
  kill_idle_chk: assert property (@(posedge clk) disable iff (rst)
    kill_req |=> (!port_ld_req && !port_st_req && !port_st_vld && !rsp_valid));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle_w |=> !rsp_valid);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

bind ldst_req_master ldst_req_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_ready     (cmd_ready),
  .kill_req      (kill_req),
  .rsp_valid     (rsp_valid),
  .rsp_error     (rsp_error),
  .rsp_rdata     (rsp_rdata),
  .port_busy     (port_busy),
  .port_ld_req   (port_ld_req),
  .port_st_req   (port_st_req),
  .port_addr_vld (port_addr_vld),
  .port_addr     (port_addr),
  .port_addr_ack (port_addr_ack),
  .port_addr_exc (port_addr_exc),
  .port_ld_vld   (port_ld_vld),
  .port_ld_data  (port_ld_data),
  .port_st_vld   (port_st_vld),
  .idle_w        (idle_w),
  .wait_addr_w   (wait_addr_w),
  .wait_load_w   (wait_load_w)
);

// File: tb/ldst_req_master_test.sv
module ldst_req_master_test;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cmd_valid = 0, cmd_is_store = 0, kill_req = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_ready, rsp_valid, rsp_error;
  logic [DW-1:0] rsp_rdata;
  logic          port_ld_req, port_st_req, port_addr_vld, port_st_vld, port_kill;
  logic [AW-1:0] port_addr;
  logic [DW-1:0] port_st_data;

  // responder-driven
  logic          r_busy = 0, r_ack = 0, r_exc = 0, r_ldv = 0;
  logic [DW-1:0] r_ld_data = '0;
  logic          stray_ack = 0, stray_exc = 0, stray_ldv = 0;
  wire           port_busy     = r_busy;
  wire           port_addr_ack = r_ack | stray_ack;
  wire           port_addr_exc = r_exc | stray_exc;
  wire           port_ld_vld   = r_ldv | stray_ldv;
  wire [DW-1:0]  port_ld_data  = r_ld_data;

  ldst_req_master #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_store(cmd_is_store), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .kill_req(kill_req), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .port_busy(port_busy), .port_ld_req(port_ld_req),
    .port_st_req(port_st_req), .port_addr_vld(port_addr_vld), .port_addr(port_addr),
    .port_addr_ack(port_addr_ack), .port_addr_exc(port_addr_exc),
    .port_ld_vld(port_ld_vld), .port_ld_data(port_ld_data),
    .port_st_vld(port_st_vld), .port_st_data(port_st_data), .port_kill(port_kill)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory responder ----------------
  int ack_lat = 0, ld_lat = 0, exc_mode = 0, busy_tail = 0;
  logic [DW-1:0] mem [16];
  int rph = 0, cnt = 0, tail = 0;
  logic [3:0] cur_a;
  logic cur_st;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'h0;
    forever begin
      @(posedge clk); #2;
      r_ack = 0; r_exc = 0; r_ldv = 0;
      if (rst || port_kill) begin
        rph = 0; r_busy = 0;
      end else begin
        case (rph)
          0: if ((port_ld_req || port_st_req) && port_addr_vld) begin
               r_busy = 1; cnt = ack_lat; cur_a = port_addr[3:0]; cur_st = port_st_req; rph = 1;
             end
          1: if (cnt > 0) cnt--;
             else if (exc_mode != 0) begin
               r_exc = 1; r_ack = (exc_mode == 2); r_busy = 0; rph = 0;
             end else begin
               r_ack = 1; cnt = ld_lat; rph = cur_st ? 3 : 2;
             end
          2: if (cnt > 0) cnt--;
             else begin r_ldv = 1; r_ld_data = mem[cur_a]; r_busy = 0; rph = 0; end
          3: if (port_st_vld) begin mem[cur_a] = port_st_data; tail = busy_tail; rph = 4; end
          default: if (tail > 0) tail--; else begin r_busy = 0; rph = 0; end
        endcase
      end
    end
  end

  // ---------------- cycle reference model ----------------
  int m_ph = 0;            // 0 idle, 1 address wait, 2 load wait, 3 store strobe
  bit m_st = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0;
  bit m_rv = 0, m_re = 0;
  logic [DW-1:0] m_rd = '0;

  always @(posedge clk) begin
    bit acc;
    acc = cmd_valid && m_ph == 0 && !port_busy && !kill_req;
    m_rv = 0; m_re = 0; m_rd = '0;
    if (rst || kill_req) m_ph = 0;
    else if (m_ph == 0) begin
      if (acc) begin m_ph = 1; m_st = cmd_is_store; m_addr = cmd_addr; m_wd = cmd_wdata; end
    end else if (m_ph == 1) begin
      if (port_addr_exc) begin m_ph = 0; m_rv = 1; m_re = 1; end
      else if (port_addr_ack) m_ph = m_st ? 3 : 2;
    end else if (m_ph == 2) begin
      if (port_ld_vld) begin m_ph = 0; m_rv = 1; m_rd = port_ld_data; end
    end else begin
      m_ph = 0; m_rv = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R1 cmd_ready", cmd_ready, (m_ph == 0) && !port_busy && !kill_req);
      check("R2 ld_req", port_ld_req, m_ph != 0 && !m_st);
      check("R2 st_req", port_st_req, m_ph != 0 && m_st);
      check("R2 addr_vld", port_addr_vld, m_ph != 0);
      if (m_ph != 0) check("R2 addr", port_addr, m_addr);
      check("R5 st_vld", port_st_vld, m_ph == 3);
      if (m_ph == 3) check("R5 st_data", port_st_data, m_wd);
      check("R10 rsp_valid", rsp_valid, m_rv);
      check("R3 rsp_error", rsp_error, m_re);
      check("R4 rsp_rdata", rsp_rdata, m_rd);
      check("R8 port_kill", port_kill, kill_req);
    end
  end

  // ---------------- stimulus ----------------
  task automatic start_cmd(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_is_store = st; cmd_addr = a; cmd_wdata = d;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic run_cmd(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output bit err, output logic [DW-1:0] rd);
    start_cmd(st, a, d);
    do @(negedge clk); while (!rsp_valid);
    err = rsp_error; rd = rsp_rdata;
  endtask

  initial begin
    bit e;
    logic [DW-1:0] rd;
    int seen;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 reset ready", cmd_ready, 1);
    check("R2 reset req", {port_ld_req, port_st_req, port_addr_vld}, 0);

    // store then load, zero latency
    run_cmd(1, 32'h3, 64'hDEAD_BEEF_0123_4567, e, rd);
    check("R6 store ok", e, 0);
    run_cmd(0, 32'h3, 64'h0, e, rd);
    check("R4 load data", rd, 64'hDEAD_BEEF_0123_4567);
    check("R4 load ok", e, 0);
    @(negedge clk);
    check("R10 rsp single", rsp_valid, 0);

    // longer latencies
    ack_lat = 3; ld_lat = 6;
    run_cmd(1, 32'h7, 64'h5555_AAAA_0F0F_F0F0, e, rd);
    check("R6 store slow", e, 0);
    run_cmd(0, 32'h7, 64'h0, e, rd);
    check("R4 load slow", rd, 64'h5555_AAAA_0F0F_F0F0);

    // address exception on a load
    exc_mode = 1; ack_lat = 1;
    run_cmd(0, 32'h3, 64'h0, e, rd);
    check("R3 exc err", e, 1);
    check("R3 exc data", rd, 0);

    // exception and ack together on a store: no strobe, memory untouched
    exc_mode = 2;
    run_cmd(1, 32'h3, 64'h1111_2222_3333_4444, e, rd);
    check("R3 both err", e, 1);
    exc_mode = 0; ack_lat = 0; ld_lat = 0;
    run_cmd(0, 32'h3, 64'h0, e, rd);
    check("R3 no write", rd, 64'hDEAD_BEEF_0123_4567);

    // busy held after store: ready must stay low
    busy_tail = 3;
    run_cmd(1, 32'h9, 64'h9999, e, rd);
    check("R7 busy tail ready", cmd_ready, 0);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (port_busy && cmd_ready) seen++;
    end
    check("R7 no ready while busy", seen, 0);
    busy_tail = 0;

    // kill during a long load wait
    ld_lat = 20;
    start_cmd(0, 32'h9, 64'h0);
    repeat (5) @(posedge clk);
    #1 kill_req = 1;
    @(negedge clk);
    check("R1 ready low on kill", cmd_ready, 0);
    check("R8 kill fwd", port_kill, 1);
    @(posedge clk); #1 kill_req = 0;
    @(negedge clk);
    check("R8 req low", {port_ld_req, port_st_req, port_addr_vld}, 0);
    seen = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (rsp_valid) seen++;
    end
    check("R8 no rsp", seen, 0);
    ld_lat = 0;

    // stray pulses while idle
    @(posedge clk); #1;
    stray_ack = 1; stray_exc = 1; stray_ldv = 1;
    @(posedge clk); #1;
    stray_ack = 0; stray_exc = 0; stray_ldv = 0;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (rsp_valid || port_addr_vld) seen++;
    end
    check("R9 stray ignored", seen, 0);
    check("R9 still ready", cmd_ready, 1);
    run_cmd(0, 32'h9, 64'h0, e, rd);
    check("R9 later load", rd, 64'h9999);

    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule